// File: doc/BRIEF.md
# Nibble-Serial CRC-16 Accumulator

This block keeps a running 16-bit cyclic redundancy check over the data nibbles that a processor reads from its memory bus. No dedicated data port feeds it: each memory read that completes presents up to `LANES` nibbles on a strobe. The block folds them into the accumulator in a single clock, lowest address first, using a reflected x^16 + x^12 + x^5 + 1 generator. Each nibble step shifts right by four and XORs in one entry of a sixteen-entry table. Entry i of that table is i times 0x1081.

Reads that land in the I/O register window are flagged by the bus and leave the accumulator alone. The accumulator is also visible as four nibble-wide registers. The processor can read back any one nibble, or preset it, without disturbing the other three. This is how software seeds the check before a block transfer and collects it afterwards.

Top module: `crc_nib_accum`

## Requirements
- R1: While `rst_n` is low the accumulator is 0x0000, so `crc_out` reads 0x0000 and every `reg_rdata` nibble reads 0.
- R2: Folding a single nibble n into accumulator value c gives (c >> 4) XOR T[(c XOR n) & 0xF], where T[i] = i * 0x1081. This equals four LSB-first bit steps of the reflected generator 0x8408. From 0x0000, nibble 0x1 gives 0x1081 and nibble 0xF gives 0xF78F.
- R3: A qualified read folds `rd_cnt` nibbles in one cycle. Lane 0 (`rd_data[3:0]`, the lowest address) is folded first, then lane 1 (`rd_data[7:4]`), and so on upward. A count above `LANES` folds all `LANES` lanes.
- R4: A read strobe with `rd_cnt` equal to 0 leaves the accumulator unchanged.
- R5: A read strobe with `rd_io` high (an I/O-window hit) leaves the accumulator unchanged, whatever the count and data.
- R6: `reg_rdata` shows, combinationally, the nibble selected by `reg_addr`. Address 0 selects bits 3:0, 1 selects 7:4, 2 selects 11:8 and 3 selects 15:12.
- R7: A register write (`reg_we` high) replaces, at the next edge, only the nibble selected by `reg_addr` with `reg_wdata`. The other three nibbles keep their values.
- R8: When a register write and a qualified read occur in the same cycle, the write is applied and the read is discarded. The other three nibbles keep their pre-cycle values.
- R9: With neither a read strobe nor a register write, the accumulator holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_valid | input | 1 | A memory read delivers nibbles this cycle |
| rd_io | input | 1 | The read hit the I/O register window (suppress update) |
| rd_cnt | input | CW | Number of nibbles in this read, lane 0 first |
| rd_data | input | 4*LANES | Read nibbles, lane k in bits 4k+3:4k |
| reg_we | input | 1 | Preset one accumulator nibble |
| reg_addr | input | 2 | Nibble select for readback and preset |
| reg_wdata | input | 4 | Preset value |
| reg_rdata | output | 4 | Selected accumulator nibble |
| crc_out | output | 16 | Full accumulator value |

## Verification
The bench builds the block with `LANES` = 5, so `rd_cnt` is three bits wide. Counts 6 and 7 therefore reach the clamp path, count 0 reaches the no-op path, and every chain length from one to five nibbles gets used. A five-lane chain is long enough to fold a nine-byte check string two nibbles per read and compare the result against the known reflected CCITT value 0x2189. Random traffic also lets preset writes collide with reads on every nibble address.

// File: rtl/crc_nib_pkg.sv
package crc_nib_pkg;

  localparam int CRC_W  = 16;
  localparam int NIB_W  = 4;
  localparam int NIBS   = CRC_W / NIB_W;
  localparam int ADDR_W = $clog2(NIBS);

  // Multiplier whose nibble multiples form the fold table.
  localparam logic [CRC_W-1:0] TBL_MUL = 16'h1081;

  typedef logic [CRC_W-1:0] crc_t;
  typedef logic [NIB_W-1:0] nib_t;

  typedef struct packed {
    logic              en;
    logic [ADDR_W-1:0] sel;
    nib_t              val;
  } preset_t;

  // i * TBL_MUL. The shifted copies do not overlap, so XOR equals the sum.
  function automatic crc_t fold_tbl(input nib_t idx);
    crc_t acc;
    acc = '0;
    for (int b = 0; b < NIB_W; b++) begin
      if (idx[b]) acc = acc ^ (TBL_MUL << b);
    end
    return acc;
  endfunction

endpackage

// File: rtl/crc_nib_step.sv
module crc_nib_step
  import crc_nib_pkg::*;
(
  input  crc_t crc_i,
  input  nib_t nib_i,
  output crc_t crc_o
);

  // Sixteen-entry table, built once from the multiplier.
  crc_t tbl [NIBS*NIBS];

  genvar gi;
  generate
    for (gi = 0; gi < NIBS*NIBS; gi++) begin : g_tbl
      assign tbl[gi] = fold_tbl(nib_t'(gi));
    end
  endgenerate

  nib_t idx;

  always_comb begin
    idx   = crc_i[NIB_W-1:0] ^ nib_i;
    crc_o = (crc_i >> NIB_W) ^ tbl[idx];
  end

endmodule

// File: rtl/crc_fold_chain.sv
module crc_fold_chain
  import crc_nib_pkg::*;
#(
  parameter  int LANES = 5,
  localparam int CW    = $clog2(LANES + 1)
) (
  input  crc_t                   crc_i,
  input  logic [NIB_W*LANES-1:0] data_i,
  input  logic [CW-1:0]          cnt_i,
  output crc_t                   crc_o
);

  // tap[k] is the value after folding lanes 0..k-1.
  crc_t tap [LANES+1];
  assign tap[0] = crc_i;

  genvar gl;
  generate
    for (gl = 0; gl < LANES; gl++) begin : g_lane
      crc_nib_step u_step (
        .crc_i (tap[gl]),
        .nib_i (data_i[gl*NIB_W +: NIB_W]),
        .crc_o (tap[gl+1])
      );
    end
  endgenerate

  logic [CW-1:0] eff_cnt;

  always_comb begin
    eff_cnt = (int'(cnt_i) > LANES) ? CW'(LANES) : cnt_i;
    crc_o   = tap[0];
    for (int k = 1; k <= LANES; k++) begin
      if (int'(eff_cnt) == k) crc_o = tap[k];
    end
  end

endmodule

// File: rtl/crc_reg_port.sv
module crc_reg_port
  import crc_nib_pkg::*;
(
  input  crc_t              crc_i,
  input  logic [ADDR_W-1:0] sel_i,
  input  nib_t              wval_i,
  output nib_t              rval_o,
  output crc_t              merged_o
);

  logic [NIBS-1:0] hit;

  genvar gn;
  generate
    for (gn = 0; gn < NIBS; gn++) begin : g_nib
      assign hit[gn] = (sel_i == ADDR_W'(gn));
      assign merged_o[gn*NIB_W +: NIB_W] =
        hit[gn] ? wval_i : crc_i[gn*NIB_W +: NIB_W];
    end
  endgenerate

  always_comb begin
    rval_o = '0;
    for (int k = 0; k < NIBS; k++) begin
      if (hit[k]) rval_o = crc_i[k*NIB_W +: NIB_W];
    end
  end

endmodule

// File: rtl/crc_rst_sync.sv
module crc_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];

endmodule

// File: rtl/crc_nib_accum.sv
module crc_nib_accum
  import crc_nib_pkg::*;
#(
  parameter  int LANES = 5,
  localparam int CW    = $clog2(LANES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rd_valid,
  input  logic                   rd_io,
  input  logic [CW-1:0]          rd_cnt,
  input  logic [NIB_W*LANES-1:0] rd_data,
  input  logic                   reg_we,
  input  logic [ADDR_W-1:0]      reg_addr,
  input  logic [NIB_W-1:0]       reg_wdata,
  output logic [NIB_W-1:0]       reg_rdata,
  output logic [CRC_W-1:0]       crc_out
);

  logic    rst_sync_n;
  crc_t    crc_q;
  crc_t    crc_d;
  logic    crc_en;
  crc_t    fold_val;
  crc_t    merge_val;
  preset_t pre;
  logic    rd_take;

  crc_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  crc_fold_chain #(.LANES(LANES)) u_fold (
    .crc_i  (crc_q),
    .data_i (rd_data),
    .cnt_i  (rd_cnt),
    .crc_o  (fold_val)
  );

  crc_reg_port u_port (
    .crc_i    (crc_q),
    .sel_i    (pre.sel),
    .wval_i   (pre.val),
    .rval_o   (reg_rdata),
    .merged_o (merge_val)
  );

  // Next-state: a preset wins over a bus read in the same cycle.
  always_comb begin
    pre.en  = reg_we;
    pre.sel = reg_addr;
    pre.val = reg_wdata;
    rd_take = rd_valid && !rd_io && (rd_cnt != '0);
    crc_en  = pre.en || rd_take;
    if (pre.en)       crc_d = merge_val;
    else if (rd_take) crc_d = fold_val;
    else              crc_d = crc_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  crc_q <= '0;
    else if (crc_en)  crc_q <= crc_d;
  end

  assign crc_out = crc_q;

endmodule

// File: rtl/crc_nib_accum_chk.sv
module crc_nib_accum_chk
  import crc_nib_pkg::*;
#(
  parameter  int LANES = 5,
  localparam int CW    = $clog2(LANES + 1)
) (
  input logic                   clk,
  input logic                   rst_sync_n,
  input logic                   rd_valid,
  input logic                   rd_io,
  input logic [CW-1:0]          rd_cnt,
  input logic [NIB_W*LANES-1:0] rd_data,
  input logic                   reg_we,
  input logic [ADDR_W-1:0]      reg_addr,
  input logic [NIB_W-1:0]       reg_wdata,
  input logic [NIB_W-1:0]       reg_rdata,
  input logic [CRC_W-1:0]       crc_out
);

  logic [CRC_W-1:0] keep_mask;
  assign keep_mask = ~(16'hF << {reg_addr, 2'b00});

  assert_reset_zero_R1: assert property (@(posedge clk)
    !rst_sync_n |=> crc_out == 16'h0000);

  assert_single_fold_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_valid && !rd_io && rd_cnt == CW'(1) && !reg_we) |=>
      crc_out == (($past(crc_out) >> 4) ^
                  (16'($past(crc_out[3:0]) ^ $past(rd_data[3:0])) * 16'h1081)));

  assert_zero_count_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_valid && rd_cnt == '0 && !reg_we) |=> $stable(crc_out));

  assert_io_hold_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_valid && rd_io && !reg_we) |=> $stable(crc_out));

  assert_write_nibble_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    reg_we |=> (4'(crc_out >> {$past(reg_addr), 2'b00}) == $past(reg_wdata)));

  assert_write_others_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    reg_we |=> ((crc_out & $past(keep_mask)) == ($past(crc_out) & $past(keep_mask))));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!rd_valid && !reg_we) |=> $stable(crc_out));

  // R6: readback nibble agrees with the full accumulator view.
  always_comb begin
    if (rst_sync_n) begin
      assert_readback_R6: assert (reg_rdata == 4'(crc_out >> {reg_addr, 2'b00}));
    end
  end

endmodule

bind crc_nib_accum crc_nib_accum_chk #(.LANES(LANES)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .rd_valid   (rd_valid),
  .rd_io      (rd_io),
  .rd_cnt     (rd_cnt),
  .rd_data    (rd_data),
  .reg_we     (reg_we),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .crc_out    (crc_out)
);

// File: tb/tb_crc_nib_accum.sv
`timescale 1ns/1ps
module tb_crc_nib_accum;

  localparam int LANES = 5;
  localparam int CW    = $clog2(LANES + 1);
  localparam int DW    = 4 * LANES;

  logic          clk;
  logic          rst_n;
  logic          rd_valid;
  logic          rd_io;
  logic [CW-1:0] rd_cnt;
  logic [DW-1:0] rd_data;
  logic          reg_we;
  logic [1:0]    reg_addr;
  logic [3:0]    reg_wdata;
  logic [3:0]    reg_rdata;
  logic [15:0]   crc_out;

  int checks;
  int failures;
  logic [15:0] model;

  crc_nib_accum #(.LANES(LANES)) dut (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_io(rd_io),
    .rd_cnt(rd_cnt), .rd_data(rd_data), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .crc_out(crc_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Bitwise serial reference: reflected generator, LSB first.
  function automatic logic [15:0] bit_step(input logic [15:0] c, input logic [3:0] n);
    logic [15:0] r;
    logic fb;
    r = c;
    for (int b = 0; b < 4; b++) begin
      fb = r[0] ^ n[b];
      r  = r >> 1;
      if (fb) r = r ^ 16'h8408;
    end
    return r;
  endfunction

  function automatic logic [15:0] ref_next(
    input logic [15:0] c, input logic v, input logic io, input int cnt,
    input logic [DW-1:0] d, input logic we, input logic [1:0] a, input logic [3:0] w);
    logic [15:0] r;
    int n;
    r = c;
    if (we) begin
      r[a*4 +: 4] = w;
    end else if (v && !io) begin
      n = (cnt > LANES) ? LANES : cnt;
      for (int k = 0; k < n; k++) r = bit_step(r, d[k*4 +: 4]);
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at negedge, let one posedge pass, compare at the next negedge.
  task automatic cyc(input logic v, input logic io, input int cnt, input logic [DW-1:0] d,
                     input logic we, input logic [1:0] a, input logic [3:0] w,
                     input string req);
    rd_valid = v; rd_io = io; rd_cnt = CW'(cnt); rd_data = d;
    reg_we = we; reg_addr = a; reg_wdata = w;
    @(negedge clk);
    model = ref_next(model, v, io, cnt, d, we, a, w);
    chk(req, crc_out, model);
    chk("R6", 16'(reg_rdata), 16'(model[a*4 +: 4]));
  endtask

  initial begin
    #100000ns;
    failures++;
    $display("FAIL watchdog expired (all requirements)");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    logic [7:0] msg [9];
    checks = 0; failures = 0;
    void'($urandom(32'd20240517));
    rst_n = 1'b0; rd_valid = 0; rd_io = 0; rd_cnt = '0; rd_data = '0;
    reg_we = 0; reg_addr = 2'd3; reg_wdata = '0;
    model = 16'h0000;
    repeat (3) @(negedge clk);
    chk("R1", crc_out, 16'h0000);
    chk("R1", 16'(reg_rdata), 16'h0000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", crc_out, 16'h0000);

    // R2 table end points, from a cleared accumulator.
    cyc(1, 0, 1, DW'(4'h1), 0, 0, 0, "R2");
    chk("R2", crc_out, 16'h1081);
    for (int a = 0; a < 4; a++) cyc(0, 0, 0, '0, 1, 2'(a), 4'h0, "R7");
    chk("R7", crc_out, 16'h0000);
    cyc(1, 0, 1, DW'(4'hF), 0, 1, 0, "R2");
    chk("R2", crc_out, 16'hF78F);

    // R7 single-nibble preset leaves others.
    cyc(0, 0, 0, '0, 1, 2'd2, 4'hA, "R7");
    chk("R7", crc_out, 16'hFA8F);
    // R4 zero count, R5 I/O window, R9 idle.
    cyc(1, 0, 0, DW'(20'h12345), 0, 0, 0, "R4");
    chk("R4", crc_out, 16'hFA8F);
    cyc(1, 1, 5, DW'(20'h9ABCD), 0, 3, 0, "R5");
    chk("R5", crc_out, 16'hFA8F);
    cyc(0, 0, 3, DW'(20'h55555), 0, 1, 0, "R9");
    chk("R9", crc_out, 16'hFA8F);
    // R8 write wins over a read.
    cyc(1, 0, 5, DW'(20'hFFFFF), 1, 2'd0, 4'h3, "R8");
    chk("R8", crc_out, 16'hFA83);
    // R3 clamp for counts 6 and 7, and ordering of lanes.
    cyc(1, 0, 7, DW'(20'h1F2E3), 0, 0, 0, "R3");
    cyc(1, 0, 6, DW'(20'h0C0D1), 0, 2, 0, "R3");
    cyc(1, 0, 3, DW'(20'h00321), 0, 1, 0, "R3");

    // R3 known check string "123456789", two nibbles per read, low nibble first.
    for (int a = 0; a < 4; a++) cyc(0, 0, 0, '0, 1, 2'(a), 4'h0, "R7");
    for (int i = 0; i < 9; i++) msg[i] = 8'h31 + 8'(i);
    for (int i = 0; i < 9; i++) cyc(1, 0, 2, DW'(msg[i]), 0, 0, 0, "R3");
    chk("R3", crc_out, 16'h2189);

    // Random traffic.
    for (int i = 0; i < 3000; i++) begin
      d = DW'({$urandom, $urandom});
      cyc(($urandom % 4) != 0, ($urandom % 5) == 0, int'($urandom % 8), d,
          ($urandom % 6) == 0, 2'($urandom), 4'($urandom), "R3");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule